// File: doc/BRIEF.md
# Parallel register bus master

This block is the host side of a narrow strobed register bus. A local requester asks for a 16-bit register read or write at an 8-bit address. The block then carries the access to a peripheral as a sequence of 8-bit byte phases on a shared data byte. The bus also has an active-low chip select, a direction line, a strobe, an address-latch line and a ready input that the peripheral drives.

Every access has the same shape. The direction line is set first. The address goes out as a written byte with the latch line high. Two value bytes follow, most significant byte first. For a write the value bytes are driven out. For a read the data lines are turned around and the peripheral supplies the bytes. At the end, chip select rises and ready is sampled. A busy peripheral on a read causes both value bytes to be fetched again. On a write it only causes chip select to be pulsed until ready drops.

Every step of the sequence changes the bus lines once and then holds them for a parameterised number of clocks. This gives the peripheral stable levels. A one-clock done pulse ends the access, and the read word is valid in that cycle.

Top module: `pbus_master`

## Requirements
- R1: While reset is asserted, and after it is released with no request, the data lines are driven (output enable high) to 0xFF. Chip select, direction, strobe and latch lines are all high, and done is low.
- R2: Each byte phase first drives chip select, strobe and latch low, with the data lines at 0. Strobe then rises while chip select is low, with the latch line and data lines unchanged from the previous clock.
- R3: Each access begins with exactly one address phase. It is a written byte with the latch line high, and data line i carries bit i of the address.
- R4: The direction line is driven low for a read and high for a write before the address phase, and it does not change while chip select is low.
- R5: A write sends the value as two written byte phases with the latch line low, bits 15:8 first and then bits 7:0. With ready low this gives exactly three strobe rises per access.
- R6: A read turns the data lines to input (output enable low) after the address phase. It then runs two strobed read phases with the latch line low, and the byte sampled first becomes bits 15:8 of the read data.
- R7: On a read, if ready is high when sampled after chip select rises, both value bytes are read again, until ready is sampled low. The read data returned is that of the last pass, and a read that is retried b times gives 1 + 2(b+1) strobe rises.
- R8: On a write, if ready is high when sampled after chip select rises, chip select is pulsed low and then high, with no further strobe. A write or read retried b times shows 1 + b chip-select rises.
- R9: Any two successive changes of the bus outputs are at least HOLD_CYCLES clocks apart. Done goes high HOLD_CYCLES*(12+2b) clocks after the clock edge that accepts a write, and HOLD_CYCLES*(11+5b) clocks after the edge that accepts a read.
- R10: Done is high for exactly one clock per access. A start seen while an access is in progress is ignored and causes no bus activity.
- R11: When done is high, the data lines are driven again (output enable high) and rest at 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| write_i | input | 1 | 1 = write access, 0 = read access |
| addr_i | input | BYTE_W | Register address |
| wdata_i | input | 2*BYTE_W | Value for a write |
| rdata_o | output | 2*BYTE_W | Word returned by the last read |
| done_o | output | 1 | One-clock end-of-access pulse |
| bus_data_o | output | BYTE_W | Data byte driven onto the bus |
| bus_data_oe_o | output | 1 | Data lines driven when high, input when low |
| bus_data_i | input | BYTE_W | Data byte sampled from the bus |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_dir_o | output | 1 | Direction, low for read, high for write |
| bus_stb_o | output | 1 | Byte phase strobe |
| bus_ale_o | output | 1 | Address-latch line, high in the address phase |
| bus_rdy_i | input | 1 | Peripheral busy indication, high while busy |

## Verification
A wrong step or phase register shows up at the very next strobe rise. It appears as the wrong latch level, a strobe while chip select is high, or extra or missing strobes, and the peripheral model counts these per access. A misrouted byte lane or retry decision appears at the done pulse, as a wrong read word or a wrong stored value. A miscounting hold timer shifts the done pulse by at least one clock against the closed-form latency of R9. It also shortens the spacing between two bus changes at the first edge where it goes wrong.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  parameter int unsigned PBUS_BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIR,
    ST_RST,
    ST_SET,
    ST_STB,
    ST_TURN,
    ST_CSH,
    ST_CSL,
    ST_RET
  } step_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_HI,
    PH_LO
  } phase_e;

  typedef struct packed {
    logic oe;
    logic cs_n;
    logic dir;
    logic stb;
    logic ale;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{oe: 1'b1, cs_n: 1'b1, dir: 1'b1, stb: 1'b1, ale: 1'b1};

endpackage

// File: rtl/pbus_hold_timer.sv
module pbus_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= RELOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pbus_tx_sel.sv
module pbus_tx_sel
  import pbus_pkg::*;
#(
  parameter int unsigned BYTE_W = PBUS_BYTE_W
) (
  input  phase_e              phase_i,
  input  logic [BYTE_W-1:0]   addr_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0]   byte_o
);
  always_comb begin
    unique case (phase_i)
      PH_ADDR: byte_o = addr_i;
      PH_HI:   byte_o = wdata_i[2*BYTE_W-1:BYTE_W];
      PH_LO:   byte_o = wdata_i[BYTE_W-1:0];
      default: byte_o = addr_i;
    endcase
  end
endmodule

// File: rtl/pbus_rx_word.sv
module pbus_rx_word #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic                cap_hi_i,
  input  logic [BYTE_W-1:0]   byte_i,
  output logic [2*BYTE_W-1:0] word_o
);
  localparam int unsigned LANES = 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    logic              sel;
    assign sel = cap_i && (cap_hi_i == (g == LANES - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  lane_q <= '0;
      else if (sel) lane_q <= byte_i;
    end

    assign word_o[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int unsigned BYTE_W = PBUS_BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic              expired_i,
  input  logic              rdy_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              accept_o,
  output logic              load_o,
  output logic              cap_o,
  output logic              cap_hi_o,
  output phase_e            phase_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] data_o,
  output ctl_t              ctl_o
);
  step_e             st_q, st_d;
  phase_e            ph_q, ph_d;
  ctl_t              ctl_q, ctl_d;
  logic [BYTE_W-1:0] dat_q, dat_d;
  logic              wr_q, wr_d;
  logic              done_q, done_d;

  // start of every byte phase: select, strobe, latch and data low
  function automatic ctl_t phase_reset(ctl_t c);
    ctl_t r;
    r      = c;
    r.cs_n = 1'b0;
    r.stb  = 1'b0;
    r.ale  = 1'b0;
    return r;
  endfunction

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    ctl_d    = ctl_q;
    dat_d    = dat_q;
    wr_d     = wr_q;
    done_d   = 1'b0;
    load_o   = 1'b0;
    cap_o    = 1'b0;
    accept_o = 1'b0;

    if (st_q == ST_IDLE) begin
      if (start_i) begin
        accept_o  = 1'b1;
        wr_d      = write_i;
        ctl_d.dir = write_i;
        st_d      = ST_DIR;
        load_o    = 1'b1;
      end
    end else if (expired_i) begin
      load_o = 1'b1;
      unique case (st_q)
        ST_DIR: begin
          ctl_d = phase_reset(ctl_q);
          dat_d = '0;
          ph_d  = PH_ADDR;
          st_d  = ST_RST;
        end
        ST_RST: begin
          if (ctl_q.oe) begin
            ctl_d.ale = (ph_q == PH_ADDR);
            dat_d     = tx_byte_i;
            st_d      = ST_SET;
          end else begin
            ctl_d.stb = 1'b1;
            st_d      = ST_STB;
          end
        end
        ST_SET: begin
          ctl_d.stb = 1'b1;
          st_d      = ST_STB;
        end
        ST_STB: begin
          cap_o = !ctl_q.oe;
          unique case (ph_q)
            PH_ADDR: begin
              if (wr_q) begin
                ctl_d = phase_reset(ctl_q);
                dat_d = '0;
                ph_d  = PH_HI;
                st_d  = ST_RST;
              end else begin
                ctl_d.oe = 1'b0;
                st_d     = ST_TURN;
              end
            end
            PH_HI: begin
              ctl_d = phase_reset(ctl_q);
              dat_d = '0;
              ph_d  = PH_LO;
              st_d  = ST_RST;
            end
            default: begin
              ctl_d.cs_n = 1'b1;
              st_d       = ST_CSH;
            end
          endcase
        end
        ST_TURN: begin
          ctl_d = phase_reset(ctl_q);
          dat_d = '0;
          ph_d  = PH_HI;
          st_d  = ST_RST;
        end
        ST_CSH: begin
          if (rdy_i && wr_q) begin
            ctl_d.cs_n = 1'b0;
            st_d       = ST_CSL;
          end else if (rdy_i) begin
            ctl_d = phase_reset(ctl_q);
            dat_d = '0;
            ph_d  = PH_HI;
            st_d  = ST_RST;
          end else begin
            ctl_d.oe = 1'b1;
            dat_d    = '1;
            st_d     = ST_RET;
          end
        end
        ST_CSL: begin
          ctl_d.cs_n = 1'b1;
          st_d       = ST_CSH;
        end
        ST_RET: begin
          done_d = 1'b1;
          load_o = 1'b0;
          st_d   = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_ADDR;
      ctl_q  <= CTL_RESET;
      dat_q  <= '1;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      ctl_q  <= ctl_d;
      dat_q  <= dat_d;
      wr_q   <= wr_d;
      done_q <= done_d;
    end
  end

  assign cap_hi_o = (ph_q == PH_HI);
  assign phase_o  = ph_q;
  assign done_o   = done_q;
  assign data_o   = dat_q;
  assign ctl_o    = ctl_q;
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 2,
  parameter int unsigned BYTE_W      = PBUS_BYTE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                write_i,
  input  logic [BYTE_W-1:0]   addr_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  output logic [2*BYTE_W-1:0] rdata_o,
  output logic                done_o,
  output logic [BYTE_W-1:0]   bus_data_o,
  output logic                bus_data_oe_o,
  input  logic [BYTE_W-1:0]   bus_data_i,
  output logic                bus_cs_no,
  output logic                bus_dir_o,
  output logic                bus_stb_o,
  output logic                bus_ale_o,
  input  logic                bus_rdy_i
);
  localparam int unsigned WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              accept, load, expired, cap, cap_hi;
  phase_e            phase;
  logic [BYTE_W-1:0] tx_byte;
  ctl_t              ctl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  pbus_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .expired_o(expired)
  );

  pbus_tx_sel #(.BYTE_W(BYTE_W)) u_tx (
    .phase_i(phase),
    .addr_i (addr_q),
    .wdata_i(wdata_q),
    .byte_o (tx_byte)
  );

  pbus_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .write_i  (write_i),
    .expired_i(expired),
    .rdy_i    (bus_rdy_i),
    .tx_byte_i(tx_byte),
    .accept_o (accept),
    .load_o   (load),
    .cap_o    (cap),
    .cap_hi_o (cap_hi),
    .phase_o  (phase),
    .done_o   (done_o),
    .data_o   (bus_data_o),
    .ctl_o    (ctl)
  );

  pbus_rx_word #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .cap_hi_i(cap_hi),
    .byte_i  (bus_data_i),
    .word_o  (rdata_o)
  );

  assign bus_data_oe_o = ctl.oe;
  assign bus_cs_no     = ctl.cs_n;
  assign bus_dir_o     = ctl.dir;
  assign bus_stb_o     = ctl.stb;
  assign bus_ale_o     = ctl.ale;
endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk #(
  parameter int unsigned HOLD_CYCLES = 2,
  parameter int unsigned BYTE_W      = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic [BYTE_W-1:0] bus_data_o,
  input logic              bus_data_oe_o,
  input logic              bus_cs_no,
  input logic              bus_dir_o,
  input logic              bus_stb_o,
  input logic              bus_ale_o
);
  localparam int unsigned PIN_W = BYTE_W + 5;
  localparam int unsigned RUN_W = $clog2(HOLD_CYCLES + 1) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HOLD_CYCLES);

  logic [PIN_W-1:0] pins, prev_q;
  logic [RUN_W-1:0] run_q;

  assign pins = {bus_data_o, bus_data_oe_o, bus_cs_no, bus_dir_o, bus_stb_o, bus_ale_o};

  // clocks the previous bus value was held, saturating at the hold count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      run_q  <= RUN_MAX;
    end else begin
      prev_q <= pins;
      if (pins != prev_q)       run_q <= RUN_W'(1);
      else if (run_q < RUN_MAX) run_q <= run_q + 1'b1;
    end
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins != prev_q) |-> (run_q >= RUN_MAX));

  p_stb_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_stb_o) |-> !bus_cs_no);

  p_stb_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_stb_o) |-> ($stable(bus_ale_o) && $stable(bus_data_o)));

  p_dir_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_cs_no |-> $stable(bus_dir_o));

  p_rd_noale_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_stb_o) && !bus_data_oe_o) |-> !bus_ale_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_rest_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bus_data_oe_o && (bus_data_o == '1)));
endmodule

bind pbus_master pbus_master_chk #(
  .HOLD_CYCLES(HOLD_CYCLES),
  .BYTE_W     (BYTE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .done_o       (done_o),
  .bus_data_o   (bus_data_o),
  .bus_data_oe_o(bus_data_oe_o),
  .bus_cs_no    (bus_cs_no),
  .bus_dir_o    (bus_dir_o),
  .bus_stb_o    (bus_stb_o),
  .bus_ale_o    (bus_ale_o)
);

// File: tb/sim_pbus_master.sv
`timescale 1ns/1ps
module sim_pbus_master;
  localparam int HOLD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        write = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        done;
  logic [7:0]  bdo;
  logic        boe, bcs_n, bdir, bstb, bale;
  logic [7:0]  bdi = '0;
  logic        brdy = 1'b0;

  always #2.5 clk = ~clk;

  pbus_master #(.HOLD_CYCLES(HOLD), .BYTE_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(write),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .done_o(done),
    .bus_data_o(bdo), .bus_data_oe_o(boe), .bus_data_i(bdi),
    .bus_cs_no(bcs_n), .bus_dir_o(bdir), .bus_stb_o(bstb),
    .bus_ale_o(bale), .bus_rdy_i(brdy)
  );

  typedef struct {
    bit          wr;
    logic [7:0]  addr;
    logic [15:0] data;
    int          busy;
    int          lat;
    int          stb;
    int          csr;
  } item_t;

  item_t       exp_q[$];
  logic [15:0] mem [256];
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  int          t0 = 0;
  int          busy_left = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // peripheral model and monitor
  logic       prev_stb = 1'b1, prev_cs_n = 1'b1, prev_done = 1'b0;
  logic [7:0] addr_cap = '0, w_hi = '0;
  logic       dir_cap = 1'b0;
  bit         rd_idx = 0, w_idx = 0, seen_rise = 0;
  int         cnt_stb = 0, cnt_ale = 0, cnt_csr = 0;
  logic [12:0] pins_prev = '1;
  int         run = 1000, min_run = 1000;

  always @(negedge clk) begin
    if (rst_n) begin
      if ({bdo, boe, bcs_n, bdir, bstb, bale} != pins_prev) begin
        if (run < min_run) min_run = run;
        run = 1;
      end else run++;
      pins_prev = {bdo, boe, bcs_n, bdir, bstb, bale};

      if (prev_done) chk(!done, "R10", "done width", 32'(done), 32'h0);

      if (bstb && !prev_stb) begin
        cnt_stb++;
        if (boe) begin
          if (bale) begin
            cnt_ale++;
            addr_cap = bdo;
            dir_cap  = bdir;
            w_idx    = 0;
          end else begin
            if (!w_idx) w_hi = bdo;
            else        mem[addr_cap] = {w_hi, bdo};
            w_idx = ~w_idx;
          end
        end else begin
          bdi    = rd_idx ? mem[addr_cap][7:0] : mem[addr_cap][15:8];
          rd_idx = ~rd_idx;
        end
      end

      if (bcs_n && !prev_cs_n) begin
        cnt_csr++;
        rd_idx    = 0;
        seen_rise = 1;
        if (!bdir && busy_left > 0) mem[addr_cap] = mem[addr_cap] + 16'h0101;
      end
      if (!bcs_n && prev_cs_n && seen_rise) begin
        seen_rise = 0;
        if (busy_left > 0) busy_left--;
      end
      brdy = (busy_left != 0);

      if (done) begin
        if (exp_q.size() == 0) chk(1'b0, "R10", "unexpected done", 32'h1, 32'h0);
        else begin
          item_t it;
          it = exp_q.pop_front();
          chk(cyc - t0 == it.lat, "R9", "latency", 32'(cyc - t0), 32'(it.lat));
          chk(cnt_ale == 1 && addr_cap == it.addr, "R3", "address phase",
              {cnt_ale[15:0], 8'h0, addr_cap}, {16'h1, 8'h0, it.addr});
          chk(dir_cap == it.wr, "R4", "direction", 32'(dir_cap), 32'(it.wr));
          chk(cnt_stb == it.stb, it.wr ? "R5" : "R7", "strobe count", 32'(cnt_stb), 32'(it.stb));
          chk(cnt_csr == it.csr, "R8", "select rises", 32'(cnt_csr), 32'(it.csr));
          if (it.wr) chk(mem[it.addr] == it.data, "R5", "stored word", 32'(mem[it.addr]), 32'(it.data));
          else       chk(rdata == it.data, it.busy > 0 ? "R7" : "R6", "read word", 32'(rdata), 32'(it.data));
          chk(boe && bdo == 8'hFF, "R11", "data rest", {23'h0, boe, bdo}, 32'h1FF);
        end
        cnt_stb = 0; cnt_ale = 0; cnt_csr = 0;
        seen_rise = 0; rd_idx = 0;
      end
      prev_done = done;
      prev_stb  = bstb;
      prev_cs_n = bcs_n;
    end
  end

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input bit wr, input logic [7:0] a, input logic [15:0] d, input int b);
    item_t it;
    it.wr = wr; it.addr = a; it.busy = b; it.csr = 1 + b;
    if (wr) begin
      it.data = d;
      it.lat  = (12 + 2 * b) * HOLD + 1;
      it.stb  = 3;
    end else begin
      it.data = mem[a] + 16'(b) * 16'h0101;
      it.lat  = (11 + 5 * b) * HOLD + 1;
      it.stb  = 1 + 2 * (b + 1);
    end
    @(negedge clk);
    busy_left = b;
    exp_q.push_back(it);
    start = 1'b1; write = wr; addr = a; wdata = d;
    t0 = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [15:0] d, input int b);
    issue(wr, a, d, b);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] keep;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0123) ^ 16'h5A00;

    repeat (3) @(negedge clk);
    chk({bdo, boe, bcs_n, bdir, bstb, bale, done} == 14'b11111111_111110, "R1", "pins in reset",
        32'({bdo, boe, bcs_n, bdir, bstb, bale, done}), 32'h3FFE);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({bdo, boe, bcs_n, bdir, bstb, bale, done} == 14'b11111111_111110, "R1", "pins idle",
        32'({bdo, boe, bcs_n, bdir, bstb, bale, done}), 32'h3FFE);

    access(1'b1, 8'h12, 16'hA55A, 0);   // R5 plain write
    access(1'b0, 8'h12, 16'h0000, 0);   // R6 read back
    access(1'b0, 8'h80, 16'h0000, 0);   // R6 untouched register
    access(1'b1, 8'h3C, 16'h00FF, 3);   // R8 write retried
    access(1'b0, 8'h3C, 16'h0000, 2);   // R7 read retried
    access(1'b1, 8'hFF, 16'hFF00, 1);   // R8 single retry
    access(1'b0, 8'h01, 16'h0000, 1);   // R7 single retry

    // R10: a second start during an access is ignored
    keep = mem[8'h77];
    issue(1'b1, 8'h44, 16'h1234, 0);
    repeat (4) @(negedge clk);
    start = 1'b1; write = 1'b1; addr = 8'h77; wdata = 16'hDEAD;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk(mem[8'h77] == keep, "R10", "ignored start", 32'(mem[8'h77]), 32'(keep));

    for (int k = 0; k < 6; k++)
      access(k[0], 8'(k * 37 + 5), 16'(k * 16'h1111 + 16'h0F0F), k % 3);

    chk(min_run >= HOLD, "R9", "min hold", 32'(min_run), 32'(HOLD));
    finish_run();
  end
endmodule